// File: doc/BRIEF.md
# 257b Inverse Transcoder with Scrambled Nibble Restoration

This block expands one 257-bit transcoded word into four 66-bit blocks. The payloads stay scrambled, because a separate descrambler further along the receive path undoes the scrambling. When a word carries control blocks, the transmitter removed the upper half of the first control block's type byte, and that half was in scrambled form. It cannot be read back from the scrambled bits that remain, so the block rebuilds it.

To do this, a self-synchronizing descrambler model with taps at 39 and 58 runs beside the scrambled stream. It descrambles the four surviving type-field bits. A fixed one-to-one nibble table then gives the plain upper nibble. That nibble is scrambled again using the running stream history, and the result is written into the gap. The history advances by 256 payload bits per accepted word, and the restored bits are part of that history.

Synchronisation is tracked by a two-state machine. `ST_COLD` is entered on reset. The transition `T_LOCK` moves it to `ST_LOCKED` on the first accepted word. `ST_LOCKED` holds through `T_STAY` until the next reset. Each output group carries a trust flag that says whether the restored nibble could be derived from complete history.

Top module: `scr_itc257_restore`

## Requirements
- R1: When `in_word[0]` is 1, the four outputs are data blocks. Block k's 64-bit payload is `in_word[64k+1 +: 64]`, and its sync bits are bit0=0 and bit1=1, so the 2-bit value at `out_blocks[66k +: 2]` is 2'b10.
- R2: When `in_word[0]` is 0, `in_word[1+k]` flags block k: 1 means data and 0 means control. A control block gets sync bits bit0=1 and bit1=0, so the 2-bit value is 2'b01.
- R3: When `in_word[0]` is 0, `in_word[256:5]` holds the payloads in block order, each starting with payload bit 0. The first control block contributes 60 bits: payload bits 3:0, then bits 63:8. Every other block contributes all 64 bits.
- R4: Payload bits 7:4 of the first control block are restored so that, in the continuous stream of payload bits (block order, bit 0 first, spanning successive words), each scrambled bit s(i) equals plain bit p(i) XOR s(i-39) XOR s(i-58).
- R5: The plain upper nibble is derived from the plain lower nibble (hex, lower→upper): 0→0, 1→E, 2→D, 3→3, 4→B, 5→5, 6→6, 7→8, 8→7, 9→9, A→A, B→4, C→C, D→2, E→1, F→F.
- R6: Outputs are registered. `out_valid` is high for exactly the cycle after each cycle in which `in_valid` is high.
- R7: While `in_valid` is low, `out_blocks` and `out_trusted` hold their values and the stream history does not advance.
- R8: `sync_ok` is low from reset until the first accepted word. It goes high one cycle after that word and stays high until the next reset.
- R9: `out_trusted` is high when history was complete at acceptance (`sync_ok` high), when the word has no control block, or when the first control block is block 1, 2 or 3.
- R10: Reset is asynchronous and active low. It clears the outputs, clears `sync_ok` and empties the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transcoded word present this cycle |
| in_word | input | 257 | Transcoded word, bit 0 first |
| out_valid | output | 1 | Four blocks present this cycle |
| out_blocks | output | 264 | Block k at bits 66k+65..66k; sync bits at the bottom, bit 0 first |
| out_trusted | output | 1 | Restored nibble derived from complete history |
| sync_ok | output | 1 | Descrambler history filled (`ST_LOCKED`) |

## Verification
Every result of a word is due exactly one clock after the edge that accepted it: the four blocks, the trust flag, and the `sync_ok` rise that follows the first word. The bench drives a word on a falling edge and reads every output on the next falling edge, halfway through the cycle in which the registered result is present. Idle stretches are checked on the falling edges that follow, and those checks confirm the held outputs. The history effect of an idle stretch shows up only in the restored nibble of the next word, so that word is compared in full on its own falling edge.

// File: rtl/itc_pkg.sv
package itc_pkg;
    localparam int unsigned BLK_N    = 4;
    localparam int unsigned PAY_W    = 64;
    localparam int unsigned HDR_W    = 2;
    localparam int unsigned BLK_W    = PAY_W + HDR_W;
    localparam int unsigned NIB_W    = 4;
    localparam int unsigned STREAM_W = BLK_N * PAY_W;
    localparam int unsigned WORD_W   = STREAM_W + 1;
    localparam int unsigned REGION_W = STREAM_W - NIB_W;
    localparam int unsigned FLAG_LO  = 1;
    localparam int unsigned IDX_W    = $clog2(BLK_N);
    localparam int unsigned TAP_NEAR = 39;
    localparam int unsigned TAP_FAR  = 58;
    localparam int unsigned EXT_W    = TAP_FAR + STREAM_W;

    // sync bits written as {bit1, bit0}
    localparam logic [HDR_W-1:0] HDR_DATA = 2'b10;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b01;

    typedef enum logic {
        ST_COLD,
        ST_LOCKED
    } sync_st_t;

    // plain lower nibble of a type field -> plain upper nibble
    function automatic logic [NIB_W-1:0] upper_of(input logic [NIB_W-1:0] lo);
        logic [NIB_W-1:0] hi;
        unique case (lo)
            4'h0: hi = 4'h0;
            4'h1: hi = 4'hE;
            4'h2: hi = 4'hD;
            4'h3: hi = 4'h3;
            4'h4: hi = 4'hB;
            4'h5: hi = 4'h5;
            4'h6: hi = 4'h6;
            4'h7: hi = 4'h8;
            4'h8: hi = 4'h7;
            4'h9: hi = 4'h9;
            4'hA: hi = 4'hA;
            4'hB: hi = 4'h4;
            4'hC: hi = 4'hC;
            4'hD: hi = 4'h2;
            4'hE: hi = 4'h1;
            4'hF: hi = 4'hF;
            default: hi = 4'h0;
        endcase
        return hi;
    endfunction
endpackage

// File: rtl/itc_unpack.sv
module itc_unpack
    import itc_pkg::*;
(
    input  logic [WORD_W-1:0]   word_i,
    output logic [STREAM_W-1:0] stream_o,
    output logic [BLK_N-1:0]    ctrl_mask_o,
    output logic                has_gap_o,
    output logic [IDX_W-1:0]    cb_idx_o
);
    logic                  all_data;
    logic [BLK_N-1:0]      flags;
    logic [REGION_W-1:0]   region;
    logic [STREAM_W-1:0]   cand [BLK_N];

    assign all_data = word_i[0];
    assign flags    = word_i[FLAG_LO +: BLK_N];
    assign region   = word_i[WORD_W-1 -: REGION_W];

    assign ctrl_mask_o = all_data ? '0 : ~flags;
    assign has_gap_o   = |ctrl_mask_o;

    always_comb begin
        cb_idx_o = '0;
        for (int k = BLK_N - 1; k >= 0; k--) begin
            if (ctrl_mask_o[k]) cb_idx_o = IDX_W'(k);
        end
    end

    // one candidate stream per possible position of the first control block
    for (genvar k = 0; k < BLK_N; k++) begin : g_cand
        localparam int unsigned GAP = k * PAY_W + NIB_W;
        assign cand[k] = {region[REGION_W-1:GAP], {NIB_W{1'b0}}, region[GAP-1:0]};
    end

    always_comb begin
        if (all_data)       stream_o = word_i[WORD_W-1:1];
        else if (has_gap_o) stream_o = cand[cb_idx_o];
        else                stream_o = {{NIB_W{1'b0}}, region};
    end
endmodule

// File: rtl/itc_nibble_fix.sv
module itc_nibble_fix
    import itc_pkg::*;
(
    input  logic [TAP_FAR-1:0]  hist_i,   // [TAP_FAR-1] is the most recent bit
    input  logic [STREAM_W-1:0] stream_i,
    input  logic                has_gap_i,
    input  logic [IDX_W-1:0]    cb_idx_i,
    output logic [STREAM_W-1:0] stream_o,
    output logic [TAP_FAR-1:0]  hist_o
);
    logic [EXT_W-1:0]  ext;
    logic [NIB_W-1:0]  regen [BLK_N];

    assign ext = {stream_i, hist_i};

    for (genvar k = 0; k < BLK_N; k++) begin : g_pos
        localparam int unsigned GAP = k * PAY_W + NIB_W;
        logic [NIB_W-1:0] plain_lo;
        logic [NIB_W-1:0] plain_hi;
        logic [NIB_W-1:0] scr_hi;

        for (genvar b = 0; b < NIB_W; b++) begin : g_bit
            localparam int unsigned PL = TAP_FAR + GAP - NIB_W + b;
            localparam int unsigned PH = TAP_FAR + GAP + b;
            assign plain_lo[b] = ext[PL] ^ ext[PL-TAP_NEAR] ^ ext[PL-TAP_FAR];
            assign scr_hi[b]   = plain_hi[b] ^ ext[PH-TAP_NEAR] ^ ext[PH-TAP_FAR];
        end

        assign plain_hi = upper_of(plain_lo);
        assign regen[k] = scr_hi;
    end

    always_comb begin
        stream_o = stream_i;
        for (int k = 0; k < BLK_N; k++) begin
            if (has_gap_i && (cb_idx_i == IDX_W'(k))) begin
                stream_o[k*PAY_W + NIB_W +: NIB_W] = regen[k];
            end
        end
    end

    assign hist_o = stream_o[STREAM_W-1 -: TAP_FAR];
endmodule

// File: rtl/itc_block_pack.sv
module itc_block_pack
    import itc_pkg::*;
(
    input  logic [STREAM_W-1:0]    stream_i,
    input  logic [BLK_N-1:0]       ctrl_mask_i,
    output logic [BLK_N*BLK_W-1:0] blocks_o
);
    for (genvar k = 0; k < BLK_N; k++) begin : g_blk
        assign blocks_o[k*BLK_W +: BLK_W] =
            {stream_i[k*PAY_W +: PAY_W], ctrl_mask_i[k] ? HDR_CTRL : HDR_DATA};
    end
endmodule

// File: rtl/scr_itc257_restore.sv
module scr_itc257_restore
    import itc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [WORD_W-1:0]      in_word,
    output logic                   out_valid,
    output logic [BLK_N*BLK_W-1:0] out_blocks,
    output logic                   out_trusted,
    output logic                   sync_ok
);
    sync_st_t                state_q;
    sync_st_t                state_d;
    logic [TAP_FAR-1:0]      hist_q;
    logic [TAP_FAR-1:0]      hist_d;
    logic [STREAM_W-1:0]     stream_raw;
    logic [STREAM_W-1:0]     stream_fix;
    logic [BLK_N-1:0]        ctrl_mask;
    logic                    has_gap;
    logic [IDX_W-1:0]        cb_idx;
    logic [BLK_N*BLK_W-1:0]  blocks_c;
    logic                    trust_c;

    itc_unpack u_unpack (
        .word_i      (in_word),
        .stream_o    (stream_raw),
        .ctrl_mask_o (ctrl_mask),
        .has_gap_o   (has_gap),
        .cb_idx_o    (cb_idx)
    );

    itc_nibble_fix u_fix (
        .hist_i    (hist_q),
        .stream_i  (stream_raw),
        .has_gap_i (has_gap),
        .cb_idx_i  (cb_idx),
        .stream_o  (stream_fix),
        .hist_o    (hist_d)
    );

    itc_block_pack u_pack (
        .stream_i    (stream_fix),
        .ctrl_mask_i (ctrl_mask),
        .blocks_o    (blocks_c)
    );

    // first control block at a later position only looks back inside this word
    assign trust_c = (state_q == ST_LOCKED) || !has_gap || (cb_idx != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLD:   if (in_valid) state_d = ST_LOCKED;   // T_LOCK
            ST_LOCKED: state_d = ST_LOCKED;                 // T_STAY
            default:   state_d = ST_COLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_blocks  <= '0;
            out_trusted <= 1'b0;
            hist_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_blocks  <= blocks_c;
                out_trusted <= trust_c;
                hist_q      <= hist_d;
            end
        end
    end

    assign sync_ok = (state_q == ST_LOCKED);
endmodule

// File: rtl/itc_restore_chk.sv
module itc_restore_chk
    import itc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [WORD_W-1:0]      in_word,
    input logic                   out_valid,
    input logic [BLK_N*BLK_W-1:0] out_blocks,
    input logic                   out_trusted,
    input logic                   sync_ok
);
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_blocks) && $stable(out_trusted)));
    a_r8_sync_rises: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> sync_ok);
    a_r8_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> sync_ok);
    a_r9_trust_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sync_ok) |=> out_trusted);
    a_r9_trust_no_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[0]) |=> out_trusted);
    a_r9_cold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sync_ok && !in_word[0] && !in_word[1]) |=> !out_trusted);
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!sync_ok && !out_valid));

    for (genvar k = 0; k < BLK_N; k++) begin : g_hdr
        a_r1_data_hdr: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_word[0]) |=> (out_blocks[k*BLK_W +: HDR_W] == HDR_DATA));
        a_r2_flag_hdr: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_word[0]) |=>
            (out_blocks[k*BLK_W +: HDR_W] == ($past(in_word[FLAG_LO+k]) ? HDR_DATA : HDR_CTRL)));
    end
endmodule

bind scr_itc257_restore itc_restore_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .out_valid   (out_valid),
    .out_blocks  (out_blocks),
    .out_trusted (out_trusted),
    .sync_ok     (sync_ok)
);

// File: tb/scr_itc257_restore_tb_top.sv
module scr_itc257_restore_tb_top;
    import itc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [256:0] in_word = '0;
    logic         out_valid;
    logic [263:0] out_blocks;
    logic         out_trusted;
    logic         sync_ok;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [57:0]  tx_h = 58'h2A5_F00D_1234_5678;  // [0] is the newest scrambled bit
    logic [256:0] stim_word;
    logic [263:0] exp_blocks;
    bit           has_cb;
    int           k0;
    bit           locked_m = 1'b0;

    // stimulus table: {expected trust, all_data, flags[3:0], low nibble, seed[15:0]}
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 1'b1, 4'b0000, 4'h0, 16'h1234},
        {1'b1, 1'b0, 4'b1110, 4'hE, 16'h0F0F},
        {1'b1, 1'b0, 4'b0000, 4'h8, 16'hBEEF},
        {1'b1, 1'b0, 4'b0111, 4'h4, 16'h7777},
        {1'b1, 1'b0, 4'b1101, 4'h2, 16'hC001},
        {1'b1, 1'b0, 4'b1011, 4'h1, 16'h5A5A},
        {1'b1, 1'b0, 4'b0110, 4'hD, 16'h9999},
        {1'b1, 1'b0, 4'b1000, 4'hB, 16'h0042}
    };

    scr_itc257_restore dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .out_valid   (out_valid),
        .out_blocks  (out_blocks),
        .out_trusted (out_trusted),
        .sync_ok     (sync_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] ref_upper(input logic [3:0] lo);
        case (lo)
            4'h0: return 4'h0;  4'h1: return 4'hE;  4'h2: return 4'hD;  4'h3: return 4'h3;
            4'h4: return 4'hB;  4'h5: return 4'h5;  4'h6: return 4'h6;  4'h7: return 4'h8;
            4'h8: return 4'h7;  4'h9: return 4'h9;  4'hA: return 4'hA;  4'hB: return 4'h4;
            4'hC: return 4'hC;  4'hD: return 4'h2;  4'hE: return 4'h1;  default: return 4'hF;
        endcase
    endfunction

    task automatic check_vec(input string req, input logic [263:0] act, input logic [263:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scramble four blocks with the bench's own scrambler and transcode them
    task automatic make_word(input bit all_data, input logic [3:0] flags,
                             input logic [3:0] fnib, input logic [15:0] seed);
        logic [31:0] r;
        logic [63:0] plain;
        logic [63:0] scr [4];
        bit          is_data [4];
        logic        s;
        logic [3:0]  f;
        int          pos;
        r = {seed, ~seed};
        has_cb = 1'b0;
        k0 = 0;
        for (int k = 0; k < 4; k++) begin
            is_data[k] = all_data || flags[k];
            if (!is_data[k] && !has_cb) begin
                has_cb = 1'b1;
                k0 = k;
            end
            for (int h = 0; h < 2; h++) begin
                r ^= r << 13;
                r ^= r >> 17;
                r ^= r << 5;
                plain[h*32 +: 32] = r;
            end
            if (!is_data[k]) begin
                f = fnib + 4'(k);
                plain[7:0] = {ref_upper(f), f};
            end
            for (int b = 0; b < 64; b++) begin
                s = plain[b] ^ tx_h[38] ^ tx_h[57];
                tx_h = {tx_h[56:0], s};
                scr[k][b] = s;
            end
            exp_blocks[k*66 +: 66] = {scr[k], is_data[k] ? 2'b10 : 2'b01};
        end
        stim_word = '0;
        if (all_data) begin
            stim_word = {scr[3], scr[2], scr[1], scr[0], 1'b1};
        end else begin
            for (int k = 0; k < 4; k++) stim_word[1+k] = is_data[k];
            pos = 5;
            for (int k = 0; k < 4; k++) begin
                for (int b = 0; b < 64; b++) begin
                    if (!(k == k0 && b >= 4 && b < 8)) begin
                        stim_word[pos] = scr[k][b];
                        pos++;
                    end
                end
            end
        end
    endtask

    task automatic send_and_check(input string req);
        bit           trust_exp;
        logic [263:0] mask;
        trust_exp = locked_m || !has_cb || (k0 != 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = stim_word;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R6 out_valid", 264'(out_valid), 264'(1'b1));
        check_vec("R9 out_trusted", 264'(out_trusted), 264'(trust_exp));
        check_vec("R8 sync_ok", 264'(sync_ok), 264'(1'b1));
        for (int k = 0; k < 4; k++)
            check_vec("R2 sync bits", 264'(out_blocks[k*66 +: 2]), 264'(exp_blocks[k*66 +: 2]));
        mask = '1;
        if (!trust_exp) mask[9:6] = 4'h0;
        check_vec(req, out_blocks & mask, exp_blocks & mask);
        locked_m = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        locked_m = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [263:0] snap;
        do_reset();
        // R10: reset state
        check_vec("R10 out_valid", 264'(out_valid), 264'(1'b0));
        check_vec("R10 out_blocks", out_blocks, '0);
        check_vec("R8 sync_ok low", 264'(sync_ok), 264'(1'b0));

        // cold start, first control block in block 0: nibble not trusted (R9)
        make_word(1'b0, 4'b1110, 4'h3, 16'hAAAA);
        send_and_check("R3 cold word");

        // table walk
        for (int i = 0; i < 8; i++) begin
            make_word(VEC[i][24], VEC[i][23:20], VEC[i][19:16], VEC[i][15:0]);
            if (VEC[i][24]) send_and_check("R1 all-data word");
            else            send_and_check("R3/R4 mixed word");
            check_vec("R9 table trust", 264'(out_trusted), 264'(VEC[i][25]));
        end

        // every lower nibble value through the table of R5
        for (int n = 0; n < 16; n++) begin
            make_word(1'b0, 4'b1110, 4'(n), 16'(n * 977 + 5));
            send_and_check("R5 nibble map");
        end

        // idle stretch: outputs held, history not advanced (R7)
        snap = out_blocks;
        repeat (4) @(negedge clk);
        check_vec("R7 out_valid idle", 264'(out_valid), 264'(1'b0));
        check_vec("R7 blocks held", out_blocks, snap);
        make_word(1'b0, 4'b1110, 4'h7, 16'h3141);
        send_and_check("R7/R4 after idle");

        // reset mid-stream: history emptied
        do_reset();
        check_vec("R10 sync_ok after reset", 264'(sync_ok), 264'(1'b0));
        make_word(1'b0, 4'b1011, 4'h9, 16'h2718);
        send_and_check("R9 cold later block");
        make_word(1'b0, 4'b0000, 4'hC, 16'h1618);
        send_and_check("R4 history reloaded");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule